// File: doc/BRIEF.md
# DMA Channel Transfer Engine

This block is a single channel of a memory-mapped DMA controller. Software programs a source pointer, a destination pointer and two control words through a small register port. Setting the enable bit starts the channel. It then copies a byte count as 32-bit words over a simple memory port: a read beat at the source, then a write beat at the destination. The words are grouped into bursts of a programmed size. Either pointer can be held fixed, so the channel can drain or fill a peripheral FIFO that sits at a single address.

The channel can run on its own in software mode. It can also be paced by peripheral request lines: each burst waits for the selected request, and a one-cycle acknowledge is returned when the burst ends. A request number of 32 or more marks that side as plain memory, and that side takes part in no handshake. When the last word has been written, the channel pulses a done flag. It raises an interrupt pulse if that is enabled, and clears its own enable bit. Writing a control word 0 with the enable bit clear stops a running channel.

Top module: `dma_xfer_channel`

## Requirements
- R1: After reset every register reads 0, the enable bit is 0, and there is no memory access, done pulse or acknowledge.
- R2: Registers sit at byte offsets 0x0 (source pointer), 0x4 (destination pointer), 0x8 (control 0) and 0xC (control 1). Control 0 holds the count in [31:16] and flags in [7:0]: 7 = source fixed, 6 = destination fixed, [5:3] = burst code, 2 = done interrupt enable, 1 = enable, 0 = software mode. Control 1 holds the source request number in [21:16], the destination request number in [13:8], next-channel in [7:3], coherent in bit 2 and fail in bit 1. Unused bits read 0.
- R3: A control 0 write with bit 1 set while the channel is idle starts a transfer of ceil(count/4) words. Each word is read from the source pointer and then written unchanged to the destination pointer. Read data returns one cycle after the read beat.
- R4: A pointer that is not fixed advances by 4 after each of its beats. A fixed pointer never changes. Reading a pointer register returns its current value.
- R5: A burst holds 2^code words for codes 0 to 4. Codes above 4 act as 4. The last burst is cut short to the words that remain.
- R6: When bit 0 is 0 and a side's request number is below 32, every burst waits until that side's request line is high. A one-cycle acknowledge is given on that line in the cycle of the burst's last write beat. Numbers of 32 or more need no handshake.
- R7: In software mode (bit 0 = 1) request lines are ignored and no acknowledge is given.
- R8: The done flag is high for one cycle, in the cycle after the last write beat. The enable bit reads 0 from the next cycle. The interrupt output pulses with done only when bit 2 is set.
- R9: A count of 0 gives a done pulse with no memory access.
- R10: A control 0 write with bit 1 clear while busy stops the channel at once, with no done pulse and no further access. If that write falls on the final write beat, the beat still completes, but no done pulse follows.
- R11: While the channel is busy, writes to the pointers, to control 1, or to control 0 with bit 1 set are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 4 | Register byte offset (read and write) |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for reg_addr |
| mem_en | output | 1 | Memory beat valid |
| mem_we | output | 1 | 1 = write beat, 0 = read beat |
| mem_addr | output | 32 | Byte address of the beat |
| mem_wdata | output | 32 | Write data |
| mem_rdata | input | 32 | Read data, one cycle after the read beat |
| periph_req | input | NREQ | Peripheral request lines |
| periph_ack | output | NREQ | Peripheral acknowledge pulses |
| xfer_done | output | 1 | Transfer completion pulse |
| done_irq | output | 1 | Completion interrupt pulse |

## Verification
A stop write from software and the final write beat of a transfer can land in the same cycle. In that case the stop must win over completion, while the beat already on the bus still completes. The bench watches the memory port until the write beat to the last destination word is on the bus. In that very cycle it drives a control 0 write with the enable bit clear. It then expects the final word in memory, the enable bit reading 0, and no done or interrupt pulse.

// File: rtl/dma_chan_pkg.sv
`timescale 1ns/1ps
package dma_chan_pkg;
  localparam logic [3:0] OFF_SRC = 4'h0;
  localparam logic [3:0] OFF_DST = 4'h4;
  localparam logic [3:0] OFF_C0  = 4'h8;
  localparam logic [3:0] OFF_C1  = 4'hC;

  localparam int C0_SRC_FIX = 7;
  localparam int C0_DST_FIX = 6;
  localparam int C0_IRQ_EN  = 2;
  localparam int C0_EN      = 1;
  localparam int C0_SW      = 0;

  localparam logic [31:0] C0_MASK = 32'hFFFF_00FD;
  localparam logic [31:0] C1_MASK = 32'h003F_3FFE;

  typedef enum logic [2:0] {
    ST_IDLE, ST_WAIT, ST_READ, ST_WRITE, ST_FIN
  } eng_state_t;
endpackage

// File: rtl/dma_chan_regs.sv
`timescale 1ns/1ps
module dma_chan_regs
  import dma_chan_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        wr,
  input  logic [3:0]  addr,
  input  logic [31:0] wdata,
  output logic [31:0] rdata,
  input  logic        rd_beat,
  input  logic        wr_beat,
  input  logic        fin,
  output logic        abort,
  output logic        en,
  output logic [31:0] src_ptr,
  output logic [31:0] dst_ptr,
  output logic [31:0] ctrl0,
  output logic [31:0] ctrl1
);
  logic [31:0] src_q, src_d, dst_q, dst_d, c0_q, c0_d, c1_q, c1_d;
  logic        en_q, en_d;

  assign abort = en_q && wr && (addr == OFF_C0) && !wdata[C0_EN];

  always_comb begin
    src_d = src_q;
    dst_d = dst_q;
    c0_d  = c0_q;
    c1_d  = c1_q;
    en_d  = en_q;
    if (rd_beat && !c0_q[C0_SRC_FIX]) src_d = src_q + 32'd4;
    if (wr_beat && !c0_q[C0_DST_FIX]) dst_d = dst_q + 32'd4;
    if (wr && !en_q) begin
      case (addr)
        OFF_SRC: src_d = wdata;
        OFF_DST: dst_d = wdata;
        OFF_C1:  c1_d  = wdata & C1_MASK;
        OFF_C0: begin
          c0_d = wdata & C0_MASK;
          en_d = wdata[C0_EN];
        end
        default: ;
      endcase
    end
    if (abort) begin
      c0_d = wdata & C0_MASK;
      en_d = 1'b0;
    end
    if (fin) en_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      src_q <= '0;
      dst_q <= '0;
      c0_q  <= '0;
      c1_q  <= '0;
      en_q  <= 1'b0;
    end else begin
      src_q <= src_d;
      dst_q <= dst_d;
      c0_q  <= c0_d;
      c1_q  <= c1_d;
      en_q  <= en_d;
    end
  end

  always_comb begin
    case (addr)
      OFF_SRC: rdata = src_q;
      OFF_DST: rdata = dst_q;
      OFF_C0:  rdata = c0_q | {30'd0, en_q, 1'b0};
      OFF_C1:  rdata = c1_q;
      default: rdata = '0;
    endcase
  end

  assign en      = en_q;
  assign src_ptr = src_q;
  assign dst_ptr = dst_q;
  assign ctrl0   = c0_q;
  assign ctrl1   = c1_q;

  assert_src_step_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_beat && !c0_q[C0_SRC_FIX]) |=> (src_q == $past(src_q) + 32'd4));
  assert_dst_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_beat && c0_q[C0_DST_FIX]) |=> $stable(dst_q));
  assert_en_drop_R8: assert property (@(posedge clk) disable iff (!rst_n)
    fin |=> !en_q);
  assert_busy_ignore_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (en_q && wr && (addr == OFF_SRC) && !rd_beat) |=> $stable(src_q));
endmodule

// File: rtl/dma_chan_hs.sv
`timescale 1ns/1ps
module dma_chan_hs #(
  parameter int NREQ = 32
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            sw_mode,
  input  logic [5:0]      src_num,
  input  logic [5:0]      dst_num,
  input  logic [NREQ-1:0] req,
  input  logic            burst_end,
  output logic            need,
  output logic            ready,
  output logic [NREQ-1:0] ack
);
  localparam int RQW = $clog2(NREQ);

  logic need_src, need_dst;
  logic [RQW-1:0] src_idx, dst_idx;

  assign src_idx  = src_num[RQW-1:0];
  assign dst_idx  = dst_num[RQW-1:0];
  assign need_src = !sw_mode && (32'(src_num) < NREQ);
  assign need_dst = !sw_mode && (32'(dst_num) < NREQ);
  assign need     = need_src || need_dst;
  assign ready    = (!need_src || req[src_idx]) && (!need_dst || req[dst_idx]);

  always_comb begin
    ack = '0;
    if (burst_end) begin
      if (need_src) ack[src_idx] = 1'b1;
      if (need_dst) ack[dst_idx] = 1'b1;
    end
  end

  assert_ack_on_end_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (|ack) |-> burst_end);
  assert_ack_lines_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(ack) <= 2);
  assert_sw_no_ack_R7: assert property (@(posedge clk) disable iff (!rst_n)
    sw_mode |-> (ack == '0));
endmodule

// File: rtl/dma_chan_engine.sv
`timescale 1ns/1ps
module dma_chan_engine
  import dma_chan_pkg::*;
#(
  parameter int CNTW = 16,
  parameter int MAXB = 4
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            en,
  input  logic            abort,
  input  logic [CNTW-1:0] cnt,
  input  logic [2:0]      bcode,
  input  logic            hs_need,
  input  logic            hs_ready,
  output logic            rd_beat,
  output logic            wr_beat,
  output logic            burst_end,
  output logic            fin
);
  localparam int WW = CNTW - 1;
  localparam int BW = MAXB + 1;

  eng_state_t st_q, st_d;
  logic [WW-1:0] words_q, words_d, words_init;
  logic [BW-1:0] beats_q, beats_d;

  function automatic logic [BW-1:0] blen(input logic [WW-1:0] rem, input logic [2:0] code);
    logic [BW-1:0] lim;
    lim = BW'(1) << ((32'(code) > MAXB) ? MAXB : 32'(code));
    if (rem < {{(WW-BW){1'b0}}, lim}) return rem[BW-1:0];
    return lim;
  endfunction

  assign words_init = cnt[CNTW-1:2] + WW'(|cnt[1:0]);

  always_comb begin
    st_d    = st_q;
    words_d = words_q;
    beats_d = beats_q;
    case (st_q)
      ST_IDLE: if (en) begin
        if (words_init == '0) st_d = ST_FIN;
        else begin
          words_d = words_init;
          beats_d = blen(words_init, bcode);
          st_d    = hs_need ? ST_WAIT : ST_READ;
        end
      end
      ST_WAIT:  if (hs_ready) st_d = ST_READ;
      ST_READ:  st_d = ST_WRITE;
      ST_WRITE: begin
        words_d = words_q - WW'(1);
        beats_d = beats_q - BW'(1);
        if (beats_q == BW'(1)) begin
          if (words_q == WW'(1)) st_d = ST_FIN;
          else begin
            beats_d = blen(words_q - WW'(1), bcode);
            st_d    = hs_need ? ST_WAIT : ST_READ;
          end
        end else st_d = ST_READ;
      end
      ST_FIN:   st_d = ST_IDLE;
      default:  st_d = ST_IDLE;
    endcase
    if (abort) st_d = ST_IDLE;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q    <= ST_IDLE;
      words_q <= '0;
      beats_q <= '0;
    end else begin
      st_q    <= st_d;
      words_q <= words_d;
      beats_q <= beats_d;
    end
  end

  assign rd_beat   = (st_q == ST_READ);
  assign wr_beat   = (st_q == ST_WRITE);
  assign burst_end = wr_beat && (beats_q == BW'(1));
  assign fin       = (st_q == ST_FIN);

  assert_done_single_R8: assert property (@(posedge clk) disable iff (!rst_n)
    fin |=> !fin);
  assert_abort_quiet_R10: assert property (@(posedge clk) disable iff (!rst_n)
    abort |=> !(rd_beat || wr_beat || fin));
  assert_wait_blocks_R6: assert property (@(posedge clk) disable iff (!rst_n)
    ((st_q == ST_WAIT) && !hs_ready && !abort) |=> !rd_beat && !wr_beat);
  assert_read_then_write_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_beat && !abort) |=> wr_beat);
endmodule

// File: rtl/dma_xfer_channel.sv
`timescale 1ns/1ps
module dma_xfer_channel
  import dma_chan_pkg::*;
#(
  parameter int NREQ = 32,
  parameter int CNTW = 16,
  parameter int MAXB = 4
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            reg_wr,
  input  logic [3:0]      reg_addr,
  input  logic [31:0]     reg_wdata,
  output logic [31:0]     reg_rdata,
  output logic            mem_en,
  output logic            mem_we,
  output logic [31:0]     mem_addr,
  output logic [31:0]     mem_wdata,
  input  logic [31:0]     mem_rdata,
  input  logic [NREQ-1:0] periph_req,
  output logic [NREQ-1:0] periph_ack,
  output logic            xfer_done,
  output logic            done_irq
);
  logic        rd_beat, wr_beat, burst_end, fin, abort, en;
  logic        hs_need, hs_ready;
  logic [31:0] src_ptr, dst_ptr, ctrl0, ctrl1;

  dma_chan_regs u_regs (
    .clk(clk), .rst_n(rst_n), .wr(reg_wr), .addr(reg_addr), .wdata(reg_wdata),
    .rdata(reg_rdata), .rd_beat(rd_beat), .wr_beat(wr_beat), .fin(fin),
    .abort(abort), .en(en), .src_ptr(src_ptr), .dst_ptr(dst_ptr),
    .ctrl0(ctrl0), .ctrl1(ctrl1)
  );

  dma_chan_hs #(.NREQ(NREQ)) u_hs (
    .clk(clk), .rst_n(rst_n), .sw_mode(ctrl0[C0_SW]),
    .src_num(ctrl1[21:16]), .dst_num(ctrl1[13:8]), .req(periph_req),
    .burst_end(burst_end), .need(hs_need), .ready(hs_ready), .ack(periph_ack)
  );

  dma_chan_engine #(.CNTW(CNTW), .MAXB(MAXB)) u_eng (
    .clk(clk), .rst_n(rst_n), .en(en), .abort(abort),
    .cnt(ctrl0[31:32-CNTW]), .bcode(ctrl0[5:3]),
    .hs_need(hs_need), .hs_ready(hs_ready),
    .rd_beat(rd_beat), .wr_beat(wr_beat), .burst_end(burst_end), .fin(fin)
  );

  assign mem_en    = rd_beat || wr_beat;
  assign mem_we    = wr_beat;
  assign mem_addr  = rd_beat ? src_ptr : dst_ptr;
  assign mem_wdata = mem_rdata;
  assign xfer_done = fin;
  assign done_irq  = fin && ctrl0[C0_IRQ_EN];

  assert_irq_gated_R8: assert property (@(posedge clk) disable iff (!rst_n)
    done_irq |-> xfer_done);
endmodule

// File: tb/dma_xfer_channel_tb.sv
`timescale 1ns/1ps
module dma_xfer_channel_tb;
  localparam real HALF = 2.5;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_wr = 1'b0;
  logic [3:0]  reg_addr = 4'h0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        mem_en, mem_we;
  logic [31:0] mem_addr, mem_wdata;
  logic [31:0] mem_rdata;
  logic [31:0] periph_req = '0;
  logic [31:0] periph_ack;
  logic        xfer_done, done_irq;

  always #(HALF) clk = ~clk;

  dma_xfer_channel u_dut (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .mem_en(mem_en),
    .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_rdata(mem_rdata), .periph_req(periph_req), .periph_ack(periph_ack),
    .xfer_done(xfer_done), .done_irq(done_irq)
  );

  function automatic logic [31:0] pat(input int i);
    return 32'hC0DE_0000 ^ (32'(i) * 32'h0000_9E37) ^ (32'(i) << 24);
  endfunction

  logic [31:0] mem [0:255];
  always @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < 256; i++) mem[i] <= pat(i);
      mem_rdata <= '0;
    end else if (mem_en) begin
      if (mem_we) mem[mem_addr[9:2]] <= mem_wdata;
      else        mem_rdata <= mem[mem_addr[9:2]];
    end
  end

  int cyc = 0, n_acc = 0, n_wr = 0, n_done = 0, n_irq = 0, n_ack = 0, bad_ack = 0;
  int last_wr_cyc = 0, done_cyc = 0, hs_line = 0;
  always @(negedge clk) if (rst_n) begin
    cyc++;
    if (mem_en) n_acc++;
    if (mem_en && mem_we) begin n_wr++; last_wr_cyc = cyc; end
    if (xfer_done) begin n_done++; done_cyc = cyc; end
    if (done_irq) n_irq++;
    n_ack += $countones(periph_ack);
    if ((periph_ack & ~(32'd1 << hs_line)) != 0) bad_ack++;
  end

  int checks = 0, fails = 0;
  bit finished = 0;

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wreg(input logic [3:0] a, input logic [31:0] v);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = v;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rreg(input logic [3:0] a, output logic [31:0] v);
    reg_addr = a;
    #1 v = reg_rdata;
  endtask

  task automatic wait_idle();
    logic [31:0] v;
    for (int i = 0; i < 5000; i++) begin
      rreg(4'h8, v);
      if (!v[1]) break;
      @(negedge clk);
    end
  endtask

  task automatic start(input logic [31:0] s, input logic [31:0] d, input int cnt,
                       input logic [7:0] flags, input logic [31:0] c1);
    wreg(4'h0, s);
    wreg(4'h4, d);
    wreg(4'hC, c1);
    wreg(4'h8, {cnt[15:0], 8'h00, flags | 8'h02});
  endtask

  function automatic int nbursts(input int w, input int code);
    int b;
    b = 1 << ((code > 4) ? 4 : code);
    return (w + b - 1) / b;
  endfunction

  initial begin : main
    logic [31:0] v;
    int b_acc, b_wr, b_done, b_irq, b_ack, b_bad;
    void'($urandom(32'd4242));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    for (int a = 0; a < 4; a++) begin
      rreg(4'(a * 4), v);
      chk(v == 0, "R1 register after reset", v, 0);
    end
    chk(!mem_en && !xfer_done && periph_ack == 0, "R1 outputs idle", {mem_en, xfer_done}, 0);

    // R2 field layout and reserved bits
    wreg(4'hC, 32'hFFFF_FFFF);
    rreg(4'hC, v);
    chk(v == 32'h003F_3FFE, "R2 control 1 readback", v, 32'h003F_3FFE);
    wreg(4'h8, 32'hFFFF_FFFD);
    rreg(4'h8, v);
    chk(v == 32'hFFFF_00FD, "R2 control 0 readback", v, 32'hFFFF_00FD);
    wreg(4'h8, 32'h0);

    // R9 zero count
    b_acc = n_acc; b_done = n_done;
    start(32'h0, 32'h200, 0, 8'h01, 32'h0020_2000);
    wait_idle(); repeat (3) @(negedge clk);
    chk(n_done - b_done == 1, "R9 zero count done", n_done - b_done, 1);
    chk(n_acc == b_acc, "R9 zero count no access", n_acc - b_acc, 0);

    // R3 R4 R8 random transfers, memory (32) or software mode
    for (int it = 0; it < 24; it++) begin
      int s, d, cnt, code, w, mism, sidx;
      bit fs, fd, sw;
      s = $urandom % 64; d = 128 + $urandom % 64; cnt = $urandom % 257;
      code = $urandom % 8; fs = 1'($urandom); fd = 1'($urandom); sw = 1'($urandom);
      w = (cnt + 3) / 4;
      b_wr = n_wr; b_done = n_done; b_irq = n_irq; b_ack = n_ack;
      start(32'(s * 4), 32'(d * 4), cnt,
            {fs, fd, 3'(code), 1'b1, 1'b0, sw}, 32'h0020_2000);
      wait_idle(); repeat (3) @(negedge clk);
      chk(n_wr - b_wr == w, "R3 write beat count", n_wr - b_wr, w);
      chk(n_done - b_done == 1 && n_irq - b_irq == 1, "R8 done and irq once",
          n_done - b_done, 1);
      chk(n_ack == b_ack, "R6 number 32 gives no acknowledge", n_ack - b_ack, 0);
      if (w > 0) chk(done_cyc == last_wr_cyc + 1, "R8 done one cycle after last write",
                     done_cyc - last_wr_cyc, 1);
      mism = 0;
      for (int k = 0; k < w; k++) begin
        sidx = fs ? s : s + k;
        if (!fd && mem[d + k] != pat(sidx)) mism++;
      end
      if (fd && w > 0 && mem[d] != pat(fs ? s : s + w - 1)) mism++;
      chk(mism == 0, "R3 copied data", mism, 0);
      rreg(4'h0, v);
      chk(v == 32'(s * 4 + (fs ? 0 : 4 * w)), "R4 source pointer", v, s * 4 + (fs ? 0 : 4 * w));
      rreg(4'h4, v);
      chk(v == 32'(d * 4 + (fd ? 0 : 4 * w)), "R4 destination pointer", v, d * 4 + (fd ? 0 : 4 * w));
    end

    // R5 R6 handshake on source line 5, code 1, 5 words
    hs_line = 5; periph_req = '0;
    b_acc = n_acc; b_ack = n_ack; b_bad = bad_ack;
    start(32'h40, 32'h300, 20, 8'h08, 32'h0005_2000);
    repeat (10) @(negedge clk);
    chk(n_acc == b_acc, "R6 waits for request", n_acc - b_acc, 0);
    periph_req[5] = 1'b1;
    wait_idle(); repeat (3) @(negedge clk);
    chk(n_ack - b_ack == nbursts(5, 1), "R5 R6 acknowledge per burst", n_ack - b_ack, 3);
    chk(bad_ack == b_bad, "R6 acknowledge on selected line only", bad_ack - b_bad, 0);

    // R5 code above 4 acts as 4, destination line 9
    hs_line = 9; periph_req = 32'hFFFF_FFFF;
    b_ack = n_ack; b_bad = bad_ack;
    start(32'h0, 32'h200, 100, 8'h38, 32'h0020_0900);
    wait_idle(); repeat (3) @(negedge clk);
    chk(n_ack - b_ack == nbursts(25, 7), "R5 burst code clamp", n_ack - b_ack, 2);
    chk(bad_ack == b_bad, "R6 destination line acknowledge", bad_ack - b_bad, 0);

    // R7 software mode ignores requests; R8 no irq without bit 2
    periph_req = '0;
    b_ack = n_ack; b_done = n_done; b_irq = n_irq; b_wr = n_wr;
    start(32'h0, 32'h200, 16, 8'h01, 32'h0005_0500);
    wait_idle(); repeat (3) @(negedge clk);
    chk(n_wr - b_wr == 4 && n_ack == b_ack, "R7 software mode", n_wr - b_wr, 4);
    chk(n_done - b_done == 1 && n_irq == b_irq, "R8 irq masked", n_irq - b_irq, 0);

    // R10 stop mid transfer
    b_done = n_done;
    start(32'h0, 32'h200, 256, 8'h01, 32'h0020_2000);
    repeat (12) @(negedge clk);
    wreg(4'h8, 32'h0);
    rreg(4'h8, v);
    chk(!v[1], "R10 enable cleared by stop", v[1], 0);
    b_acc = n_acc;
    repeat (20) @(negedge clk);
    chk(n_acc == b_acc && n_done == b_done, "R10 no access or done after stop",
        n_acc - b_acc, 0);

    // R10 stop in the same cycle as the final write beat
    b_done = n_done; b_wr = n_wr; b_irq = n_irq;
    start(32'h80, 32'h320, 12, 8'h05, 32'h0020_2000);
    for (int i = 0; i < 200; i++) begin
      @(negedge clk);
      if (mem_en && mem_we && mem_addr == 32'h328) break;
    end
    reg_wr = 1'b1; reg_addr = 4'h8; reg_wdata = 32'h0;
    @(negedge clk);
    reg_wr = 1'b0;
    repeat (4) @(negedge clk);
    chk(n_done == b_done && n_irq == b_irq, "R10 stop beats completion", n_done - b_done, 0);
    chk(n_wr - b_wr == 3 && mem[202] == pat(34), "R10 final beat completes", n_wr - b_wr, 3);
    rreg(4'h8, v);
    chk(!v[1], "R10 enable low after late stop", v[1], 0);

    // R11 writes while busy are ignored
    start(32'h10, 32'h200, 200, 8'h01, 32'h0020_2000);
    repeat (5) @(negedge clk);
    wreg(4'h0, 32'hDEAD_0000);
    wreg(4'h8, 32'h0004_0003);
    wait_idle(); repeat (2) @(negedge clk);
    rreg(4'h0, v);
    chk(v == 32'h10 + 32'd200, "R11 pointer write ignored", v, 32'h10 + 200);
    rreg(4'h8, v);
    chk(v[31:16] == 16'd200, "R11 control 0 write ignored", v[31:16], 200);

    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    #(HALF * 2 * 190000);
    if (!finished) begin
      checks++; fails++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule